// File: doc/BRIEF.md
# TDM Signalling-Channel Serial Receiver

This block recovers a slow signalling character stream that rides inside one channel of a time-division multiplexed frame. Once per frame a strobe presents the channel's 8-bit sample. The block takes the top 1, 2 or 8 bits of that sample, in order from the most significant bit down, and passes them one per clock into a character deframer. The deframer either packs bits straight into bytes, or hunts for a start bit and then checks data, optional even parity and the stop bit. Each finished byte goes into an 8-entry receive queue together with three status flags: parity error, framing error and overflow. A microprocessor reads the head of the queue and pops it.

Software sets the block up through one 8-bit control register at bus address 41h. The register selects the bit order, the bits taken per frame, the framing mode, parity, start/stop framing and the enable. Clearing the enable empties the queue and drops any character that was partly collected.

Top module: `sigch_rx`

## Requirements
- R1: A synchronous reset clears the control register to 00h. A bus write to address 41h loads the register, laid out as bit7 transmit order, bit6 receive order (`ro`), bits5-4 rate code, bit3 message mode (`mm`), bit2 enable (`en`), bit1 parity enable (`pe`) and bit0 start/stop enable (`ss`). The register reads back on `ctrl_rdata`, and writes to any other address leave it unchanged.
- R2: The rate code decides how many bits are taken from each frame: 00 takes 1 bit, 01 takes 2 and 10 takes 8. The unused code 11 takes 1 bit. Bits are taken from `chan_byte` starting at bit 7 and moving down, and the remaining lower bits have no effect.
- R3: While `en`=0 the queue is empty (`rx_count`=0 within two clocks of the write), frame strobes are ignored, and any character that was partly collected is dropped.
- R4: With `mm`=0 and `ss`=0, collection starts with the first bit after enable. Every 8 bits form one byte, with no start, stop or parity bit, even when `pe`=1. The byte is stored with its error flags clear.
- R5: With `mm`=1, or with `ss`=1, the deframer discards 1 bits while it waits. The first 0 bit is the start bit. The next 8 bits are data, and the bit after the data (or after the parity bit) is the stop bit.
- R6: In a framed character with `pe`=1, one parity bit follows the data and comes before the stop bit. `rx_par_err` is set when the data bits and the parity bit together hold an odd number of ones.
- R7: In a framed character, a stop bit of 0 sets `rx_frm_err` on that byte. The deframer then goes back to hunting for a start bit.
- R8: With `ro`=0 the first data bit received becomes `rx_data[0]`. With `ro`=1 it becomes `rx_data[7]`.
- R9: The queue holds 8 bytes in arrival order. `rx_data` and the flags show the head entry, `rx_pop` removes it, and `rx_count`/`rx_empty` give the fill level. A pop while the queue is empty has no effect.
- R10: A byte that completes while the queue is full is discarded and `rx_count` stays at 8. The next byte that is stored carries `rx_ovf`=1. Bytes stored after that carry `rx_ovf`=0.
- R11: Bits of a frame are consumed one per clock. A byte whose last bit arrives in a frame is readable 10 clocks after that frame's strobe. While enabled, strobes must be at least 9 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register contents |
| frame_stb | input | 1 | One-clock pulse per TDM frame |
| chan_byte | input | 8 | Channel sample for this frame |
| rx_pop | input | 1 | Remove the head entry |
| rx_data | output | 8 | Head entry data byte |
| rx_par_err | output | 1 | Head entry parity error |
| rx_frm_err | output | 1 | Head entry framing error |
| rx_ovf | output | 1 | Head entry follows a dropped byte |
| rx_empty | output | 1 | Queue empty |
| rx_count | output | 4 | Number of queued entries |

## Verification
Some properties are checked every cycle by assertions. The queue level never goes above its depth, and it holds when a byte arrives at a full queue. Disabling clears the queue. Frame strobes never overlap a frame that is still draining. A framed byte is pushed exactly when a stop bit is consumed and never while the deframer is hunting. Other behaviour can only be shown by the bench's scenarios, run against a behavioural reference: bit assembly order, parity and framing verdicts on chosen characters, ignored low channel bits in the narrow rates, overflow marking on the next stored byte, and the loss of a partial character across a disable.

// File: rtl/sigch_pkg.sv
package sigch_pkg;

  localparam int DATA_W = 8;

  // Control register image, bit 7 down to bit 0
  typedef struct packed {
    logic       tx_msb_first;
    logic       rx_msb_first;
    logic [1:0] rate;
    logic       msg_mode;
    logic       rx_en;
    logic       par_en;
    logic       frm_en;
  } ctrl_t;

  typedef enum logic [1:0] {DF_HUNT, DF_DATA, DF_PAR, DF_STOP} df_state_t;

  typedef struct packed {
    logic              ovf;
    logic              frm_err;
    logic              par_err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // Bits consumed per frame for a rate code; spare code behaves as 1
  function automatic logic [3:0] bits_per_frame(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd2;
      2'b10:   return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sigch_ctrl_reg.sv
module sigch_ctrl_reg
  import sigch_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output ctrl_t             ctrl_q
);

  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= ctrl_t'(bus_wdata);
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(ctrl_q)); // R1

endmodule

// File: rtl/sigch_bit_feeder.sv
module sigch_bit_feeder
  import sigch_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            frame_stb,
  input  logic [CH_W-1:0] chan_byte,
  input  logic [1:0]      rate,
  output logic            bit_vld,
  output logic            bit_val
);

  localparam int CNT_W = $clog2(CH_W + 1);

  logic [CH_W-1:0]  sh;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh   <= '0;
      left <= '0;
    end else if (frame_stb) begin
      sh   <= chan_byte;
      left <= CNT_W'(bits_per_frame(rate));
    end else if (left != '0) begin
      sh   <= {sh[CH_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_vld = (left != '0);
  assign bit_val = sh[CH_W-1];

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (rst)
    (en && frame_stb) |-> (left == '0)); // R11

  AST_FEED_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !frame_stb && left != '0) |=> (left == $past(left) - 1'b1)); // R2

endmodule

// File: rtl/sigch_deframer.sv
module sigch_deframer
  import sigch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  ctrl_t             cfg,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_perr,
  output logic              byte_ferr
);

  localparam int CNT_W = $clog2(DATA_W);

  df_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] shifted;
  logic              ones;
  logic              framed;
  logic              use_par;
  logic              last;

  assign framed  = cfg.msg_mode | cfg.frm_en;
  assign use_par = cfg.par_en & framed;
  assign last    = (cnt == CNT_W'(DATA_W - 1));
  assign shifted = cfg.rx_msb_first ? {sr[DATA_W-2:0], bit_val}
                                    : {bit_val, sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= DF_HUNT;
      cnt       <= '0;
      sr        <= '0;
      ones      <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_perr <= 1'b0;
      byte_ferr <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (bit_vld) begin
        if (!framed) begin
          sr <= shifted;
          if (last) begin
            byte_vld  <= 1'b1;
            byte_data <= shifted;
            byte_perr <= 1'b0;
            byte_ferr <= 1'b0;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          case (state)
            DF_HUNT: begin
              if (!bit_val) begin
                state <= DF_DATA;
                cnt   <= '0;
                ones  <= 1'b0;
              end
            end
            DF_DATA: begin
              sr   <= shifted;
              ones <= ones ^ bit_val;
              if (last) begin
                cnt   <= '0;
                state <= use_par ? DF_PAR : DF_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            DF_PAR: begin
              ones  <= ones ^ bit_val;
              state <= DF_STOP;
            end
            default: begin
              byte_vld  <= 1'b1;
              byte_data <= sr;
              byte_perr <= use_par & ones;
              byte_ferr <= ~bit_val;
              state     <= DF_HUNT;
            end
          endcase
        end
      end
    end
  end

  AST_PUSH_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    (en && bit_vld && framed && state == DF_STOP) |=> byte_vld); // R5

  AST_HUNT_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (en && bit_vld && framed && state == DF_HUNT) |=> !byte_vld); // R5

  AST_RAW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (en && bit_vld && !framed) |=> (!byte_vld || (!byte_perr && !byte_ferr))); // R4

endmodule

// File: rtl/sigch_rx_fifo.sv
module sigch_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          push;
  logic          pop;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr && !full;
  assign pop   = rd && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R9

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd && !clr) |=> (count == $past(count))); // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty); // R3

endmodule

// File: rtl/sigch_rx.sv
module sigch_rx
  import sigch_pkg::*;
#(
  parameter int                FIFO_DEPTH = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h41
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [7:0]                      bus_wdata,
  output logic [7:0]                      ctrl_rdata,
  input  logic                            frame_stb,
  input  logic [DATA_W-1:0]               chan_byte,
  input  logic                            rx_pop,
  output logic [DATA_W-1:0]               rx_data,
  output logic                            rx_par_err,
  output logic                            rx_frm_err,
  output logic                            rx_ovf,
  output logic                            rx_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count
);

  ctrl_t             ctrl;
  logic              bit_vld;
  logic              bit_val;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_data;
  logic              byte_perr;
  logic              byte_ferr;
  logic              ovf_pend;
  logic              fifo_full;
  rx_entry_t         wr_entry;
  rx_entry_t         head;

  sigch_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl)
  );

  sigch_bit_feeder #(.CH_W(DATA_W)) u_feed (
    .clk(clk), .rst(rst), .en(ctrl.rx_en), .frame_stb(frame_stb),
    .chan_byte(chan_byte), .rate(ctrl.rate),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  sigch_deframer u_defr (
    .clk(clk), .rst(rst), .en(ctrl.rx_en), .bit_vld(bit_vld),
    .bit_val(bit_val), .cfg(ctrl), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_perr(byte_perr), .byte_ferr(byte_ferr)
  );

  // A dropped byte marks the next byte that does get stored
  always_ff @(posedge clk) begin
    if (rst || !ctrl.rx_en)        ovf_pend <= 1'b0;
    else if (byte_vld && fifo_full) ovf_pend <= 1'b1;
    else if (byte_vld)              ovf_pend <= 1'b0;
  end

  assign wr_entry = '{ovf: ovf_pend, frm_err: byte_ferr,
                      par_err: byte_perr, data: byte_data};

  sigch_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(!ctrl.rx_en), .wr(byte_vld),
    .wdata(wr_entry), .rd(rx_pop), .rdata(head), .count(rx_count),
    .full(fifo_full), .empty(rx_empty)
  );

  assign ctrl_rdata = ctrl;
  assign rx_data    = head.data;
  assign rx_par_err = head.par_err;
  assign rx_frm_err = head.frm_err;
  assign rx_ovf     = head.ovf;

  AST_OVF_MARK: assert property (@(posedge clk) disable iff (rst)
    (ctrl.rx_en && byte_vld && fifo_full) |=> ovf_pend); // R10

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rx_en |=> (!bit_vld && !byte_vld)); // R3

endmodule

// File: tb/sigch_rx_tb.sv
module sigch_rx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       frame_stb = 1'b0;
  logic [7:0] chan_byte = '0;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_par_err, rx_frm_err, rx_ovf, rx_empty;
  logic [3:0] rx_count;

  always #2.5 clk = ~clk;

  sigch_rx u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .frame_stb(frame_stb),
    .chan_byte(chan_byte), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_ovf(rx_ovf),
    .rx_empty(rx_empty), .rx_count(rx_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  m_ctrl = '0;
  int          ms = 0;
  int          mcnt = 0;
  int          mones = 0;
  bit          mbits[8];
  bit          movf = 0;
  logic [10:0] mq[$];
  bit          sq[$];
  int          fcnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] compose();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) d[m_ctrl[6] ? 7 - i : i] = mbits[i];
    return d;
  endfunction

  function automatic void model_reset();
    mq.delete();
    ms = 0; mcnt = 0; mones = 0; movf = 0;
  endfunction

  function automatic void model_push(input logic [7:0] d, input bit fe, input bit pe);
    if (mq.size() == 8) movf = 1;
    else begin
      mq.push_back({movf, fe, pe, d});
      movf = 0;
    end
  endfunction

  function automatic void model_bit(input bit b);
    bit framed = m_ctrl[3] | m_ctrl[0];
    bit usep   = m_ctrl[1] & framed;
    if (!framed) begin
      mbits[mcnt] = b; mcnt++;
      if (mcnt == 8) begin model_push(compose(), 0, 0); mcnt = 0; end
    end else begin
      case (ms)
        0: if (b == 0) begin ms = 1; mcnt = 0; mones = 0; end
        1: begin
          mbits[mcnt] = b; mones += int'(b); mcnt++;
          if (mcnt == 8) ms = usep ? 2 : 3;
        end
        2: begin mones += int'(b); ms = 3; end
        default: begin
          model_push(compose(), !b, usep && (mones % 2 == 1));
          ms = 0;
        end
      endcase
    end
  endfunction

  function automatic int nbits();
    case (m_ctrl[5:4])
      2'b01: return 2;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic write_ctrl(input logic [7:0] a, input logic [7:0] v);
    bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
    if (a == 8'h41) begin
      m_ctrl = v;
      if (!v[2]) model_reset();
    end
    @(negedge clk);
  endtask

  task automatic configure(input logic [7:0] v);
    write_ctrl(8'h41, v & 8'hFB);
    write_ctrl(8'h41, v);
    chk(ctrl_rdata == v, "R1", "ctrl readback", ctrl_rdata, v);
  endtask

  task automatic send_frame(input logic [7:0] b, input string req);
    frame_stb = 1; chan_byte = b;
    if (m_ctrl[2]) for (int i = 0; i < nbits(); i++) model_bit(b[7 - i]);
    @(negedge clk);
    frame_stb = 0;
    repeat (9) @(negedge clk);
    chk(rx_count == 4'(mq.size()), req, "count", rx_count, mq.size());
    repeat (2) @(negedge clk);
  endtask

  // stream bits in wire order
  task automatic add_char(input logic [7:0] d, input bit bad_par, input bit stop_b);
    bit p = ^d ^ bad_par;
    sq.push_back(0);
    for (int i = 0; i < 8; i++) sq.push_back(m_ctrl[6] ? d[7 - i] : d[i]);
    if (m_ctrl[1]) sq.push_back(p);
    sq.push_back(stop_b);
  endtask

  task automatic flush_stream(input string req);
    while (sq.size() > 0) begin
      logic [7:0] b;
      fcnt++;
      b = 8'(fcnt * 37);
      for (int i = 0; i < nbits(); i++)
        b[7 - i] = (sq.size() > 0) ? sq.pop_front() : 1'b1;
      send_frame(b, req);
    end
  endtask

  task automatic pop_check(input string req);
    logic [10:0] e;
    chk(!rx_empty, req, "not empty", rx_empty, 0);
    e = (mq.size() > 0) ? mq.pop_front() : 11'h0;
    chk({rx_ovf, rx_frm_err, rx_par_err, rx_data} == e, req, "head entry",
        {rx_ovf, rx_frm_err, rx_par_err, rx_data}, e);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctrl_rdata == 8'h00, "R1", "reset ctrl", ctrl_rdata, 0);
    chk(rx_empty && rx_count == 0, "R9", "reset empty", rx_count, 0);

    write_ctrl(8'h41, 8'hF3);
    chk(ctrl_rdata == 8'hF3, "R1", "ctrl write", ctrl_rdata, 8'hF3);
    write_ctrl(8'h40, 8'h00);
    chk(ctrl_rdata == 8'hF3, "R1", "other address ignored", ctrl_rdata, 8'hF3);

    // R4 raw 8-bit, LSB-first then MSB-first; R11 latency
    configure(8'h24);
    send_frame(8'hB4, "R11");
    pop_check("R4");
    configure(8'h64);
    send_frame(8'h3C, "R8");
    pop_check("R8");

    // R2 two bits per frame, low bits vary
    configure(8'h14);
    send_frame(8'h9F, "R2"); send_frame(8'h40, "R2");
    send_frame(8'hC7, "R2"); send_frame(8'h2A, "R2");
    pop_check("R2");
    // R2 spare rate code
    configure(8'h34);
    for (int i = 0; i < 8; i++) send_frame(8'((i * 77) ^ 8'h5A), "R2");
    pop_check("R2");

    // R4 raw mode with parity enable set: no parity expected
    configure(8'h26);
    send_frame(8'hE1, "R4"); send_frame(8'h07, "R4");
    pop_check("R4"); pop_check("R4");

    // R5 message mode, idle ones then characters split across frames
    configure(8'h2C);
    send_frame(8'hFF, "R5");
    add_char(8'hA7, 0, 1); add_char(8'h00, 0, 1); add_char(8'hFF, 0, 1);
    flush_stream("R5");
    pop_check("R5"); pop_check("R5"); pop_check("R5");

    // R5 message mode at 1 bit per frame
    configure(8'h0C);
    add_char(8'h6B, 0, 1);
    flush_stream("R5");
    pop_check("R5");

    // R6 start/stop framing with parity, good and bad
    configure(8'h27);
    add_char(8'h5C, 0, 1); add_char(8'h5C, 1, 1); add_char(8'h01, 1, 1);
    flush_stream("R6");
    pop_check("R6"); pop_check("R6"); pop_check("R6");

    // R7 missing stop, then recovery; R8 MSB-first framed
    configure(8'h6D);
    add_char(8'h93, 0, 0); add_char(8'h2E, 0, 1);
    flush_stream("R7");
    pop_check("R7"); pop_check("R8");

    // R10 overflow
    configure(8'h24);
    for (int i = 0; i < 10; i++) send_frame(8'(i * 19 + 3), "R10");
    chk(rx_count == 8, "R10", "full count", rx_count, 8);
    pop_check("R9");
    send_frame(8'hC3, "R10");
    for (int i = 0; i < 8; i++) pop_check("R10");
    pop_check_empty();
    send_frame(8'h11, "R10");
    pop_check("R10");

    // R3 disable clears, ignores frames, drops partial character
    send_frame(8'h55, "R3"); send_frame(8'hAA, "R3");
    write_ctrl(8'h41, 8'h20);
    chk(rx_count == 0 && rx_empty, "R3", "cleared", rx_count, 0);
    send_frame(8'h00, "R3");
    chk(rx_count == 0, "R3", "ignored while off", rx_count, 0);
    configure(8'h14);
    send_frame(8'h80, "R3"); send_frame(8'h40, "R3");
    write_ctrl(8'h41, 8'h10);
    configure(8'h14);
    send_frame(8'hC0, "R3"); send_frame(8'h00, "R3");
    send_frame(8'h40, "R3"); send_frame(8'h80, "R3");
    pop_check("R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pop_check_empty();
    chk(rx_empty, "R9", "empty", rx_empty, 1);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    @(negedge clk);
    chk(rx_count == 0, "R9", "pop on empty", rx_count, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule